// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block turns the raw oscillator clock of a small 8-bit microcontroller core into instruction-cycle timing. A configuration bit picks the cycle length: two oscillator periods when the bit is low and four when it is high. A new length is adopted only at the boundary between instruction cycles. A phase counter steps through the oscillator periods of the current cycle. A start-of-cycle strobe marks phase zero, and a timer tick marks the final phase, so the timer advances once per instruction cycle at Fosc/2 or Fosc/4.

The decoder presents three class flags for the instruction in its execute cycle. One marks flow changes such as jump, call and the returns. One marks conditional skips. One marks instructions that write the program counter register. The sequencer samples the flags on the final phase of an execute cycle. If any flag is set, the following instruction cycle becomes a bubble: flush is raised and execute-valid is dropped for that whole cycle. This gives such instructions two instruction cycles.

The control is a two-state machine. `SEQ_EXEC` is a normal execute cycle. `SEQ_BUBBLE` is the discarded second cycle. The transition EXEC→BUBBLE is taken at the end of an execute cycle with any class flag set. EXEC→EXEC is taken at the end of an execute cycle with no flag set. BUBBLE→EXEC is always taken at the end of a bubble cycle. All transitions happen only on the final phase.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is asserted, phase is 0, cyc_strobe is 1, exec_valid is 1, flush is 0, and in 2-period mode tmr_tick is 0.
- R2: With the option bit low, each instruction cycle lasts 2 clocks and the phase runs 0,1.
- R3: With the option bit high, each instruction cycle lasts 4 clocks and the phase runs 0,1,2,3.
- R4: tmr_tick is high on exactly one clock per instruction cycle, the final phase, and cyc_strobe follows it on the next clock.
- R5: The option bit is sampled only on the final phase of a cycle. A value that is held on other phases and removed before the final phase has no effect on cycle length.
- R6: An execute cycle with no class flag set is followed by another execute cycle (exec_valid 1, flush 0).
- R7: The flow flag (bit 2 of the class vector) in an execute cycle makes the next instruction cycle a bubble: flush 1, exec_valid 0, for exactly one instruction cycle.
- R8: The skip flag (bit 1) has the same effect as R7.
- R9: The program-counter-write flag (bit 0) has the same effect as R7.
- R10: Class flags present during a bubble cycle are ignored. The cycle after a bubble is always an execute cycle.
- R11: Class flags are sampled only on the final phase. Flags raised earlier and dropped before the final phase do not cause a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | Option bit: 0 gives 2-period cycles, 1 gives 4-period cycles |
| cls_flow | input | 1 | Decoder class: jump, call or return |
| cls_skip | input | 1 | Decoder class: conditional skip |
| cls_pcwr | input | 1 | Decoder class: write to the program counter register |
| cyc_strobe | output | 1 | High on phase 0 of each instruction cycle |
| phase | output | 2 | Oscillator period index within the cycle |
| tmr_tick | output | 1 | Timer clock-enable, high on the final phase |
| exec_valid | output | 1 | Current cycle executes the fetched word |
| flush | output | 1 | Current cycle is a bubble |

## Verification
The assertions assume that the option bit and class flags change only between clock edges, and that the option bit is held steady while reset is asserted. They also assume that the decoder keeps its flags valid up to the final phase of an execute cycle. The stimulus changes every input on the falling edge. It sets the option bit before releasing reset. Mid-cycle toggles are applied only in the directed cases that test sampling on the final phase.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

    typedef enum logic {
        SEQ_EXEC   = 1'b0,
        SEQ_BUBBLE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic flow;
        logic skip;
        logic pcwr;
    } dec_class_t;

endpackage

// File: rtl/cyc_phase_ctr.sv
module cyc_phase_ctr #(
    parameter int FAST_PERIODS = 2,
    parameter int SLOW_PERIODS = 4,
    parameter int PH_W         = $clog2(SLOW_PERIODS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_mode,
    output logic [PH_W-1:0] phase_o,
    output logic            at_start_o,
    output logic            at_end_o
);
    localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_PERIODS - 1);
    localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_PERIODS - 1);

    logic            mode_q;
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] last_ph;

    always_comb begin
        last_ph = mode_q ? SLOW_LAST : FAST_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= slow_mode;
        end else if (phase_q == last_ph) begin
            phase_q <= '0;
            mode_q  <= slow_mode;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    always_comb begin
        phase_o    = phase_q;
        at_start_o = (phase_q == '0);
        at_end_o   = (phase_q == last_ph);
    end

    // R2
    fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && phase_q == FAST_LAST) |=> (phase_q == '0));

    // R3
    slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && phase_q != SLOW_LAST) |=> (phase_q == $past(phase_q) + PH_W'(1)));

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) |-> $stable(mode_q));

endmodule

// File: rtl/cyc_stall_fsm.sv
module cyc_stall_fsm
    import cyc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       at_end,
    input  dec_class_t cls,
    output logic       exec_valid,
    output logic       flush
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       any_cls;

    always_comb begin
        any_cls = cls.flow | cls.skip | cls.pcwr;
        state_d = state_q;
        if (at_end) begin
            unique case (state_q)
                SEQ_EXEC:   state_d = any_cls ? SEQ_BUBBLE : SEQ_EXEC;
                SEQ_BUBBLE: state_d = SEQ_EXEC;
                default:    state_d = SEQ_EXEC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_EXEC;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        exec_valid = 1'b0;
        flush      = 1'b0;
        unique case (state_q)
            SEQ_EXEC:   exec_valid = 1'b1;
            SEQ_BUBBLE: flush      = 1'b1;
            default:    exec_valid = 1'b1;
        endcase
    end

    // R7
    bubble_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && at_end) |=> (exec_valid && !flush));

    // R6
    plain_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && at_end && !any_cls) |=> exec_valid);

    // R11
    mid_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_end && !flush) |=> !flush);

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import cyc_seq_pkg::*;
#(
    parameter int FAST_PERIODS = 2,
    parameter int SLOW_PERIODS = 4,
    parameter int PH_W         = $clog2(SLOW_PERIODS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_mode,
    input  logic            cls_flow,
    input  logic            cls_skip,
    input  logic            cls_pcwr,
    output logic            cyc_strobe,
    output logic [PH_W-1:0] phase,
    output logic            tmr_tick,
    output logic            exec_valid,
    output logic            flush
);
    logic       at_end;
    dec_class_t cls;

    always_comb begin
        cls.flow = cls_flow;
        cls.skip = cls_skip;
        cls.pcwr = cls_pcwr;
    end

    cyc_phase_ctr #(
        .FAST_PERIODS (FAST_PERIODS),
        .SLOW_PERIODS (SLOW_PERIODS),
        .PH_W         (PH_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_mode  (slow_mode),
        .phase_o    (phase),
        .at_start_o (cyc_strobe),
        .at_end_o   (at_end)
    );

    cyc_stall_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .at_end     (at_end),
        .cls        (cls),
        .exec_valid (exec_valid),
        .flush      (flush)
    );

    always_comb begin
        tmr_tick = at_end;
    end

    // R4
    tick_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick |=> cyc_strobe);

    // R10
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid != flush));

endmodule

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic       cls_flow = 1'b0;
    logic       cls_skip = 1'b0;
    logic       cls_pcwr = 1'b0;
    logic       cyc_strobe;
    logic [1:0] phase;
    logic       tmr_tick;
    logic       exec_valid;
    logic       flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    instr_cycle_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_mode  (slow_mode),
        .cls_flow   (cls_flow),
        .cls_skip   (cls_skip),
        .cls_pcwr   (cls_pcwr),
        .cyc_strobe (cyc_strobe),
        .phase      (phase),
        .tmr_tick   (tmr_tick),
        .exec_valid (exec_valid),
        .flush      (flush)
    );

    // vector: {slow, flow, skip, pcwr}
    localparam logic [3:0] VEC [10] = '{
        4'b0000, 4'b0100, 4'b0010, 4'b0001, 4'b1000,
        4'b1100, 4'b1011, 4'b0000, 4'b1001, 4'b1110
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts at a falling edge on phase 0, ends at the next phase 0.
    task automatic run_cycle(output int len, output int fl, output int ev, output int ticks);
        fl = int'(flush);
        ev = int'(exec_valid);
        len = 0;
        ticks = 0;
        do begin
            if (tmr_tick) ticks++;
            @(negedge clk);
            len++;
        end while (!cyc_strobe && len < 10);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int len, fl, ev, tk;
        bit prev_slow;

        @(negedge clk);
        @(negedge clk);
        check("R1 phase", int'(phase), 0);
        check("R1 strobe", int'(cyc_strobe), 1);
        check("R1 exec_valid", int'(exec_valid), 1);
        check("R1 flush", int'(flush), 0);
        check("R1 tick", int'(tmr_tick), 0);
        rst_n = 1'b1;
        prev_slow = 1'b0;

        for (int i = 0; i < 10; i++) begin
            bit s, bub;
            s   = VEC[i][3];
            bub = |VEC[i][2:0];
            slow_mode = s;
            cls_flow  = VEC[i][2];
            cls_skip  = VEC[i][1];
            cls_pcwr  = VEC[i][0];
            run_cycle(len, fl, ev, tk);
            check(prev_slow ? "R3 len old mode" : "R2 len old mode", len, prev_slow ? 4 : 2);
            check("R4 ticks", tk, 1);
            check("R6 exec cycle", ev, 1);
            cls_flow = 1'b0;
            cls_skip = 1'b0;
            cls_pcwr = 1'b0;
            run_cycle(len, fl, ev, tk);
            check(s ? "R3 len" : "R2 len", len, s ? 4 : 2);
            check("R4 ticks", tk, 1);
            check(VEC[i][2] ? "R7 flush" : VEC[i][1] ? "R8 flush" :
                  VEC[i][0] ? "R9 flush" : "R6 flush", fl, int'(bub));
            check(bub ? "R7 exec_valid" : "R6 exec_valid", ev, int'(!bub));
            if (bub) begin
                run_cycle(len, fl, ev, tk);
                check("R7 bubble once flush", fl, 0);
                check("R7 bubble once exec", ev, 1);
            end
            prev_slow = s;
        end

        // R10: flags held through the bubble are ignored
        slow_mode = 1'b0;
        cls_flow  = 1'b1;
        run_cycle(len, fl, ev, tk);
        check("R10 first exec len", len, 4);
        run_cycle(len, fl, ev, tk);
        check("R10 bubble flush", fl, 1);
        check("R10 after bubble exec", int'(exec_valid), 1);
        check("R10 after bubble flush", int'(flush), 0);
        cls_flow = 1'b0;
        run_cycle(len, fl, ev, tk);
        run_cycle(len, fl, ev, tk);
        check("R10 no second bubble", fl, 0);

        // R11: flag dropped before final phase (slow mode)
        slow_mode = 1'b1;
        run_cycle(len, fl, ev, tk);
        check("R11 switch len", len, 2);
        cls_skip = 1'b1;
        @(negedge clk);
        cls_skip = 1'b0;
        len = 1;
        while (!cyc_strobe && len < 10) begin
            @(negedge clk);
            len++;
        end
        check("R11 slow len", len, 4);
        check("R11 no bubble flush", int'(flush), 0);
        check("R11 no bubble exec", int'(exec_valid), 1);

        // R5: option toggled off and back before the final phase
        @(negedge clk);
        slow_mode = 1'b0;
        @(negedge clk);
        slow_mode = 1'b1;
        len = 2;
        while (!cyc_strobe && len < 10) begin
            @(negedge clk);
            len++;
        end
        check("R5 current len", len, 4);
        run_cycle(len, fl, ev, tk);
        check("R5 glitch ignored len", len, 4);

        // R5: option cleared mid-cycle applies only from the next cycle
        @(negedge clk);
        slow_mode = 1'b0;
        len = 1;
        while (!cyc_strobe && len < 10) begin
            @(negedge clk);
            len++;
        end
        check("R5 len unchanged", len, 4);
        run_cycle(len, fl, ev, tk);
        check("R5 new len", len, 2);
        check("R2 phase at strobe", int'(phase), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule